// File: doc/BRIEF.md
# SPI Slave Link Setup Frame Generator

This block acts as an SPI master that brings a 32-bit-word SPI slave into its command mode. One start pulse sends two 8-byte frames back to back. The first is a reset frame. The second is an init frame that carries the slave's option flags, a fixed-busy word count and a CRC7 check field.

The block drives the serial clock, the data line and an active-low chip select. The fixed-busy word count is sampled from `cfg_busy_words` when the start pulse is accepted. A host normally drives this count as (busy window bytes − 4) / 4. A one-cycle `done` pulse marks the end of the sequence.

The control machine has five states:
- `ST_IDLE` moves to `ST_SEND_RST` on an accepted start.
- `ST_SEND_RST` moves to `ST_GAP` when the shifter reports its last bit.
- `ST_GAP` moves to `ST_SEND_INIT` after `GAP_CYCLES` clocks with chip select high.
- `ST_SEND_INIT` moves to `ST_FINISH` when the shifter reports its last bit.
- `ST_FINISH` moves back to `ST_IDLE` while `done` is pulsed.

Top module: `spi_link_init_gen`

## Requirements
- R1: After reset, `cs_n` is 1 and `sclk`, `mosi` and `done` are 0.
- R2: The first frame of a sequence is 64 bits, all of them 1.
- R3: In the init frame, byte 0 is 0x00, byte 1 is 0x40, bytes 2 and 3 are 0xFF, and byte 7 is 0x00.
- R4: Init frame byte 6 holds the fixed-busy count in bits 2:0, and its bits 7:3 are 0.
- R5: Init frame byte 5 is 0x79 OR'd with 0x80, where bit 7 is set only when the fixed-busy count is nonzero.
- R6: Init frame byte 4 is {crc, 1'b1}. Here crc is a CRC7 with polynomial x^7+x^3+1 and a zero start value. It is computed MSB first over bytes 1, 0, 7, 6, 5, in that order.
- R7: Each frame is sent byte 0 first and MSB first. It spans exactly 64 rising `sclk` edges with `cs_n` held low throughout. Between the two frames, `cs_n` stays high for at least `GAP_CYCLES` clocks.
- R8: A `start` pulse while a sequence is in progress is ignored. No extra frame and no extra `done` pulse result from it.
- R9: `done` is high for exactly one cycle: the cycle after `cs_n` rises at the end of the init frame. It never follows the reset frame.
- R10: `sclk` is low whenever `cs_n` is high, and `mosi` changes only while `sclk` is low (SPI mode 0).
- R11: `cfg_busy_words` is sampled only when `start` is accepted. Later changes do not alter the init frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to send the setup sequence |
| cfg_busy_words | input | 3 | Fixed-busy word count placed in the init frame |
| sclk | output | 1 | Serial clock to the slave, idle low |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Active-low chip select |
| done | output | 1 | One-cycle pulse when the sequence has finished |

## Verification
The bench captures both frames the way a slave would and compares the init frame with one built from the requirements. It covers fixed-busy counts of zero and nonzero, and the maximum count. A design that ignored zero would set bit 7 of byte 5 wrongly. A design that fed the CRC bytes in their natural order would produce a wrong byte 4.

The bench also changes the configuration and re-pulses `start` partway through a sequence. A design that re-sampled the configuration would send the new count. A design that restarted would emit a third frame or a second `done`.

The bench also checks the gap between frames and where `done` falls relative to the chip-select edge. A design that got either wrong would pulse `done` too early, or after the reset frame.

// File: rtl/spi_init_pkg.sv
package spi_init_pkg;

    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 8;
    localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
    localparam int CRC_W       = 7;
    localparam int CRC_BYTES   = 5;
    localparam int BUSY_W      = 3;

    localparam logic [CRC_W-1:0]  CRC_POLY      = 7'h09;
    localparam logic [BYTE_W-1:0] INIT_START_TX = 8'h40;
    localparam logic [BYTE_W-1:0] OPT_FLAGS     = 8'h79;
    localparam logic [BYTE_W-1:0] BUSY_ENABLE   = 8'h80;
    localparam logic [BYTE_W-1:0] STOP_BIT      = 8'h01;
    localparam logic [4:0]        CMD_MASK_VAL  = 5'd0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND_RST,
        ST_GAP,
        ST_SEND_INIT,
        ST_FINISH
    } init_state_e;

endpackage

// File: rtl/spi_init_crc7.sv
module spi_init_crc7
    import spi_init_pkg::*;
#(
    parameter int MSG_BYTES = 5
) (
    input  logic [BYTE_W*MSG_BYTES-1:0] msg,
    output logic [CRC_W-1:0]            crc
);

    localparam int MSG_BITS = BYTE_W * MSG_BYTES;

    // Serial CRC unrolled over the message, first byte in the top bits.
    always_comb begin
        logic fb;
        crc = '0;
        for (int i = MSG_BITS - 1; i >= 0; i--) begin
            fb  = crc[CRC_W-1] ^ msg[i];
            crc = {crc[CRC_W-2:0], 1'b0};
            if (fb) crc = crc ^ CRC_POLY;
        end
    end

endmodule

// File: rtl/spi_init_frame_build.sv
module spi_init_frame_build
    import spi_init_pkg::*;
(
    input  logic [BUSY_W-1:0]     busy_words,
    output logic [FRAME_BITS-1:0] rst_frame,
    output logic [FRAME_BITS-1:0] init_frame
);

    logic [BYTE_W-1:0]           ib [FRAME_BYTES];
    logic [BYTE_W*CRC_BYTES-1:0] crc_msg;
    logic [CRC_W-1:0]            crc;
    logic [BYTE_W-1:0]           opt_byte;
    logic [BYTE_W-1:0]           cnt_byte;

    assign opt_byte = OPT_FLAGS | ((busy_words != '0) ? BUSY_ENABLE : 8'h00);
    assign cnt_byte = {CMD_MASK_VAL, busy_words};

    assign ib[0] = 8'h00;
    assign ib[1] = INIT_START_TX;
    assign ib[2] = 8'hFF;
    assign ib[3] = 8'hFF;
    assign ib[5] = opt_byte;
    assign ib[6] = cnt_byte;
    assign ib[7] = 8'h00;

    // Check field covers the bytes in the order the slave expects.
    assign crc_msg = {ib[1], ib[0], ib[7], ib[6], ib[5]};

    spi_init_crc7 #(.MSG_BYTES(CRC_BYTES)) u_crc (
        .msg (crc_msg),
        .crc (crc)
    );

    assign ib[4] = {crc, STOP_BIT[0]};

    // Byte 0 occupies the top of the vector so it leaves first.
    for (genvar g = 0; g < FRAME_BYTES; g++) begin : g_pack
        assign init_frame[FRAME_BITS-1-BYTE_W*g -: BYTE_W] = ib[g];
        assign rst_frame [FRAME_BITS-1-BYTE_W*g -: BYTE_W] = 8'hFF;
    end

endmodule

// File: rtl/spi_init_shifter.sv
module spi_init_shifter
    import spi_init_pkg::*;
#(
    parameter int HALF_CYCLES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] data,
    output logic                  sclk,
    output logic                  mosi,
    output logic                  fin
);

    localparam int HC_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam int BC_W = $clog2(FRAME_BITS);
    localparam logic [HC_W-1:0] HC_LAST  = HC_W'(HALF_CYCLES - 1);
    localparam logic [BC_W-1:0] BIT_LAST = BC_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [HC_W-1:0]       hcnt;
    logic [BC_W-1:0]       bcnt;
    logic                  active;
    logic                  sclk_q;
    logic                  fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            hcnt   <= '0;
            bcnt   <= '0;
            active <= 1'b0;
            sclk_q <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load) begin
                shreg  <= data;
                hcnt   <= '0;
                bcnt   <= '0;
                active <= 1'b1;
                sclk_q <= 1'b0;
            end else if (active) begin
                if (hcnt == HC_LAST) begin
                    hcnt <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        if (bcnt == BIT_LAST) begin
                            active <= 1'b0;
                            fin_q  <= 1'b1;
                        end else begin
                            bcnt  <= bcnt + 1'b1;
                            shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
                        end
                    end
                end else begin
                    hcnt <= hcnt + 1'b1;
                end
            end
        end
    end

    assign sclk = sclk_q;
    assign mosi = active & shreg[FRAME_BITS-1];
    assign fin  = fin_q;

endmodule

// File: rtl/spi_link_init_gen.sv
module spi_link_init_gen
    import spi_init_pkg::*;
#(
    parameter int HALF_CYCLES = 2,
    parameter int GAP_CYCLES  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [2:0] cfg_busy_words,
    output logic       sclk,
    output logic       mosi,
    output logic       cs_n,
    output logic       done
);

    localparam int GC_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [GC_W-1:0] GAP_LAST = GC_W'(GAP_CYCLES - 1);

    init_state_e           state, nxt;
    logic [GC_W-1:0]       gap_cnt;
    logic [BUSY_W-1:0]     busy_lat;
    logic [FRAME_BITS-1:0] rst_frame, init_frame, load_data;
    logic                  load, fin, gap_last;
    logic                  cs_n_q, done_q;

    assign gap_last = (gap_cnt == GAP_LAST);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start)    nxt = ST_SEND_RST;
            ST_SEND_RST:  if (fin)      nxt = ST_GAP;
            ST_GAP:       if (gap_last) nxt = ST_SEND_INIT;
            ST_SEND_INIT: if (fin)      nxt = ST_FINISH;
            ST_FINISH:                  nxt = ST_IDLE;
            default:                    nxt = ST_IDLE;
        endcase
    end

    assign load      = ((state == ST_IDLE) && start) || ((state == ST_GAP) && gap_last);
    assign load_data = (state == ST_IDLE) ? rst_frame : init_frame;

    // State register with its counter and configuration latch.
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            gap_cnt  <= '0;
            busy_lat <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start) busy_lat <= cfg_busy_words;
            if (state == ST_GAP) gap_cnt <= gap_cnt + 1'b1;
            else                 gap_cnt <= '0;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_q <= 1'b1;
            done_q <= 1'b0;
        end else begin
            cs_n_q <= !((nxt == ST_SEND_RST) || (nxt == ST_SEND_INIT));
            done_q <= (state == ST_FINISH);
        end
    end

    spi_init_frame_build u_build (
        .busy_words (busy_lat),
        .rst_frame  (rst_frame),
        .init_frame (init_frame)
    );

    spi_init_shifter #(.HALF_CYCLES(HALF_CYCLES)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .data (load_data),
        .sclk (sclk),
        .mosi (mosi),
        .fin  (fin)
    );

    assign cs_n = cs_n_q;
    assign done = done_q;

endmodule

// File: rtl/spi_init_checker.sv
module spi_init_checker (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic done
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
    AST_DONE_AFTER_CS_RISE: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && $past(cs_n) && !$past(cs_n, 2))); // R9
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sclk); // R10
    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R10
    AST_MOSI_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $stable(mosi)); // R10
    AST_CS_LOW_WHILE_CLOCKING: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> !$past(cs_n)); // R7

endmodule

bind spi_link_init_gen spi_init_checker u_chk (
    .clk  (clk),
    .rst  (rst),
    .cs_n (cs_n),
    .sclk (sclk),
    .mosi (mosi),
    .done (done)
);

// File: tb/spi_link_init_gen_test.sv
module spi_link_init_gen_test;

    localparam int GAP = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] cfg = 3'd0;
    logic       sclk, mosi, cs_n, done;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    spi_link_init_gen #(.HALF_CYCLES(2), .GAP_CYCLES(GAP)) uut (
        .clk (clk), .rst (rst), .start (start), .cfg_busy_words (cfg),
        .sclk (sclk), .mosi (mosi), .cs_n (cs_n), .done (done)
    );

    // Slave-side monitor, sampled on the falling clock edge.
    logic [63:0] cap;
    logic [63:0] frames [4];
    int          nbits  [4];
    int          nframes, nb, done_cnt, done_bad, mosi_bad, idle_bad, high_run, gap_seen;
    logic        sclk_d, cs_d, cs_dd, mosi_d;

    always @(negedge clk) begin
        if (rst) begin
            cap = '0; nframes = 0; nb = 0; done_cnt = 0; done_bad = 0;
            mosi_bad = 0; idle_bad = 0; high_run = 0; gap_seen = 0;
            sclk_d = 0; cs_d = 1; cs_dd = 1; mosi_d = 0;
        end else begin
            if (!cs_n && sclk && !sclk_d) begin cap = {cap[62:0], mosi}; nb++; end
            if (sclk && sclk_d && mosi !== mosi_d) mosi_bad++;
            if (cs_n && sclk) idle_bad++;
            if (cs_n && !cs_d) begin
                if (nframes < 4) begin frames[nframes] = cap; nbits[nframes] = nb; end
                nframes++; nb = 0; high_run = 0;
            end
            if (!cs_n && cs_d && nframes == 1) gap_seen = high_run;
            if (cs_n) high_run++;
            if (done) begin
                done_cnt++;
                if (!(cs_n && cs_d && !cs_dd) || nframes < 2) done_bad++;
            end
            cs_dd = cs_d; cs_d = cs_n; sclk_d = sclk; mosi_d = mosi;
        end
    end

    function automatic logic [6:0] ref_crc(input logic [39:0] m);
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic f = c[6] ^ m[i];
            c = {c[5:0], 1'b0};
            if (f) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [63:0] ref_init(input logic [2:0] n);
        logic [7:0] b [8];
        b[0] = 8'h00; b[1] = 8'h40; b[2] = 8'hFF; b[3] = 8'hFF; b[7] = 8'h00;
        b[6] = {5'd0, n};
        b[5] = 8'h79 | ((n != 0) ? 8'h80 : 8'h00);
        b[4] = {ref_crc({b[1], b[0], b[7], b[6], b[5]}), 1'b1};
        return {b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (done_cnt == 0 && t < 3000) begin @(negedge clk); t++; end
        if (done_cnt == 0) begin
            n_fail++; n_checks++;
            $display("FAIL R9: actual no done expected done within 3000 cycles");
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic reset_dut();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Full sequence with the given count; optional late changes.
    task automatic run_seq(input logic [2:0] n, input bit disturb, input string tag);
        reset_dut();
        cfg = n;
        pulse_start();
        if (disturb) begin
            repeat (40) @(negedge clk);
            cfg = ~n;                          // R11 late config change
            pulse_start();                     // R8 start during reset frame
            repeat (300) @(negedge clk);
            pulse_start();                     // R8 start during init frame
        end
        wait_done();
        repeat (600) @(negedge clk);
        $display("scenario %s", tag);
        check("R8 frame count", nframes, 2);
        check("R9 one done pulse", done_cnt, 1);
        check("R9 done placement", done_bad, 0);
        check("R2 reset frame", frames[0], 64'hFFFF_FFFF_FFFF_FFFF);
        check("R7 reset frame bits", nbits[0], 64);
        check("R7 init frame bits", nbits[1], 64);
        check("R7 gap length", (gap_seen >= GAP), 1);
        check("R3 fixed bytes", {frames[1][63:32], frames[1][7:0]},
              {ref_init(n)[63:32], ref_init(n)[7:0]});
        check("R4 count byte", frames[1][15:8], ref_init(n)[15:8]);
        check("R5 option byte", frames[1][23:16], ref_init(n)[23:16]);
        check("R6 crc byte", frames[1][31:24], ref_init(n)[31:24]);
        if (disturb) check("R11 latched config", frames[1], ref_init(n));
        check("R10 mosi stable / sclk idle", mosi_bad + idle_bad, 0);
    endtask

    initial begin
        #1_000_000;
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        reset_dut();
        check("R1 reset outputs", {cs_n, sclk, mosi, done}, 4'b1000);
        run_seq(3'd1, 1'b0, "count one");
        run_seq(3'd0, 1'b0, "count zero");
        run_seq(3'd7, 1'b0, "count max");
        run_seq(3'd2, 1'b1, "start and config disturbed");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule